// File: doc/BRIEF.md
# Interpolating Phase-to-Period Correction Table

This block turns a signed phase-shift fraction into a target oscillator period. The phase word is signed fixed point with 24 fractional bits, and it spans one full turn from -pi to +pi. The block uses the phase word to address a table of correction factors that a processor writes during calibration. It blends the two neighbouring entries by linear interpolation. It then scales the live drive period by the blended factor. The result is the period the oscillator should aim for next, in fixed point with 20 fractional bits, where one unit is one core clock.

The upstream divider delivers a new phase word at most once every 25 core clocks. For that reason each result is worked out over several clocks, one operation per stage, instead of in one deep cycle. Input and output are valid/ready streams:

- An input word is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` stays low from the edge that accepts a word until the edge on which its result is taken.
- A result is offered on `out_valid`. It stays frozen for as long as `out_ready` is low.
- The producer may hold `in_valid` high while the block is busy. The word is then simply not taken until `in_ready` returns.

The table is loaded through a plain write strobe, address and data.

Top module: `phase_corr_table`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Input handshake and hold:
  - A word is accepted on an edge with `in_valid` and `in_ready` both high.
  - `in_ready` is then 0 until the result is taken.
  - `out_valid` rises after the third rising edge, counting the accepting edge as the first.
  - While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_period` hold unchanged.
  - `in_ready` returns to 1 one edge after the result is taken.
- R3: Address and fraction are taken from the phase word:
  - The table address is the top 5 bits of the 25-bit phase word with its sign bit inverted. This is offset binary, so -1.0 maps to entry 0 and 0.0 maps to entry 16.
  - The low 20 bits form an unsigned interpolation fraction `f`.
- R4: The factor is K = e0 + floor((e1 - e0) * f / 2^20). Here e0 is the entry at the address and e1 is the entry at the address plus one. Entries are unsigned 18-bit values with 16 fractional bits, so 65536 means 1.0.
- R5: At address 31, e1 is entry 31 itself. There is no wrap to entry 0.
- R6: The output is floor(in_period * K / 2^16). `in_period` and `out_period` are unsigned 30-bit values with 20 fractional bits.
- R7: When that product exceeds 2^30 - 1, `out_period` is 2^30 - 1.
- R8: Table writes and their timing:
  - A pulse on `tbl_we` writes `tbl_data` into entry `tbl_addr`.
  - A word accepted on a later edge uses the new entry.
  - A word accepted on the same edge as the write uses the old entry.
  - A write made while a word is in flight does not change that word's result.
- R9: Reset sets every table entry to 1.0 (65536). An uncalibrated block therefore returns the drive period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table entry to write |
| tbl_data | input | 18 | Correction factor, 16 fractional bits |
| in_valid | input | 1 | Phase word and drive period are valid |
| in_ready | output | 1 | Block can accept a word |
| in_phase | input | 25 | Signed phase fraction, 24 fractional bits |
| in_period | input | 30 | Current drive period, 20 fractional bits |
| out_valid | output | 1 | Target period is valid |
| out_ready | input | 1 | Consumer takes the target period |
| out_period | output | 30 | Target period, 20 fractional bits |

## Verification
Wrong internal state shows up at the ports in different ways:
- A stuck or misordered sequencer shows within one clock as a wrong level on `in_ready` or `out_valid`. That is because the expected handshake timing is fixed at three edges.
- A wrong address split, a missing clamp or a bad blend shows as a wrong `out_period` on the very next result. The bench uses unequal ramp tables to make such errors visible, and it probes the end entries and the midpoints.
- A table cell that was not written, or was written at the wrong moment, shows on the first word that addresses it. This covers a write on the accepting edge and a write during flight, and the bench compares both against the old and new expected values.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INTERP,
    ST_SCALE,
    ST_HOLD
  } pct_state_e;
endpackage

// File: rtl/pct_table.sv
// Register-file correction table with two read ports that return an entry
// and its upper neighbour. The neighbour is clamped at the top entry.
module pct_table #(
  parameter int IDX_W = 5,
  parameter int K_W   = 18,
  parameter logic [K_W-1:0] K_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [K_W-1:0]   wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [K_W-1:0]   rd_cur,
  output logic [K_W-1:0]   rd_nxt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [K_W-1:0] cells [DEPTH];
  logic [IDX_W-1:0] nxt_idx;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        cells[i] <= K_INIT;
      end else if (wr_en && (wr_addr == IDX_W'(i))) begin
        cells[i] <= wr_data;
      end
    end
  end

  always_comb begin
    nxt_idx = (rd_idx == LAST) ? rd_idx : rd_idx + 1'b1;
    rd_cur  = cells[rd_idx];
    rd_nxt  = cells[nxt_idx];
  end
endmodule

// File: rtl/pct_interp.sv
// Linear blend between two table entries, using an unsigned fraction.
module pct_interp #(
  parameter int K_W  = 18,
  parameter int FR_W = 20
) (
  input  logic [K_W-1:0]  e0,
  input  logic [K_W-1:0]  e1,
  input  logic [FR_W-1:0] frac,
  output logic [K_W-1:0]  k
);
  localparam int PW = K_W + FR_W + 2;
  localparam logic signed [PW-1:0] K_MAX = PW'({1'b0, {K_W{1'b1}}});

  logic signed [PW-1:0] diff_x;
  logic signed [PW-1:0] frac_x;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] step;
  logic signed [PW-1:0] sum;

  always_comb begin
    diff_x = PW'($signed({1'b0, e1})) - PW'($signed({1'b0, e0}));
    frac_x = $signed(PW'({1'b0, frac}));
    prod   = diff_x * frac_x;
    step   = prod >>> FR_W;
    sum    = PW'($signed({1'b0, e0})) + step;
    if (sum < 0) begin
      k = '0;
    end else if (sum > K_MAX) begin
      k = '1;
    end else begin
      k = sum[K_W-1:0];
    end
  end
endmodule

// File: rtl/pct_scale.sv
// Multiplies the drive period by the correction factor and saturates the result.
module pct_scale #(
  parameter int PER_W  = 30,
  parameter int K_W    = 18,
  parameter int K_FRAC = 16
) (
  input  logic [PER_W-1:0] per,
  input  logic [K_W-1:0]   k,
  output logic [PER_W-1:0] res
);
  localparam int WW = PER_W + K_W;

  logic [WW-1:0] wide;
  logic [WW-1:0] shifted;
  logic          over;

  always_comb begin
    wide    = {{K_W{1'b0}}, per} * {{PER_W{1'b0}}, k};
    shifted = wide >> K_FRAC;
    over    = (shifted >> PER_W) != '0;
    res     = over ? {PER_W{1'b1}} : shifted[PER_W-1:0];
  end
endmodule

// File: rtl/phase_corr_table.sv
module phase_corr_table
  import pct_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int PH_W   = 25,
  parameter int K_W    = 18,
  parameter int K_FRAC = 16,
  parameter int PER_W  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [K_W-1:0]   tbl_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PH_W-1:0]  in_phase,
  input  logic [PER_W-1:0] in_period,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PER_W-1:0] out_period
);
  localparam int FR_W = PH_W - IDX_W;
  localparam logic [K_W-1:0] K_ONE = K_W'(1) << K_FRAC;
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  pct_state_e state;

  logic [IDX_W-1:0] rd_idx;
  logic [FR_W-1:0]  rd_frac;
  logic [K_W-1:0]   rd_cur, rd_nxt;
  logic [IDX_W-1:0] idx_q;
  logic [K_W-1:0]   e0_q, e1_q, k_q, k_w;
  logic [FR_W-1:0]  frac_q;
  logic [PER_W-1:0] per_q, scaled, out_q;

  // Offset-binary address: inverting the sign bit maps -1.0 to entry 0.
  assign rd_idx  = {~in_phase[PH_W-1], in_phase[PH_W-2 -: IDX_W-1]};
  assign rd_frac = in_phase[FR_W-1:0];

  pct_table #(.IDX_W(IDX_W), .K_W(K_W), .K_INIT(K_ONE)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_data),
    .rd_idx  (rd_idx),
    .rd_cur  (rd_cur),
    .rd_nxt  (rd_nxt)
  );

  pct_interp #(.K_W(K_W), .FR_W(FR_W)) u_interp (
    .e0   (e0_q),
    .e1   (e1_q),
    .frac (frac_q),
    .k    (k_w)
  );

  pct_scale #(.PER_W(PER_W), .K_W(K_W), .K_FRAC(K_FRAC)) u_scale (
    .per (per_q),
    .k   (k_q),
    .res (scaled)
  );

  // Sequencer: snapshot the operands, blend, scale, then hold the result.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx_q  <= '0;
      e0_q   <= '0;
      e1_q   <= '0;
      frac_q <= '0;
      per_q  <= '0;
      k_q    <= '0;
      out_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            idx_q  <= rd_idx;
            e0_q   <= rd_cur;
            e1_q   <= rd_nxt;
            frac_q <= rd_frac;
            per_q  <= in_period;
            state  <= ST_INTERP;
          end
        end
        ST_INTERP: begin
          k_q   <= k_w;
          state <= ST_SCALE;
        end
        ST_SCALE: begin
          out_q <= scaled;
          state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready   = (state == ST_IDLE);
  assign out_valid  = (state == ST_HOLD);
  assign out_period = out_q;

  // R2: accepting a word makes the block busy on the next cycle.
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2: an offered result that is not taken stays frozen.
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_period)));

  // R4: the blended factor lies between the two entries.
  a_r4_blend_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INTERP) |->
      (((k_w >= e0_q) && (k_w <= e1_q)) || ((k_w <= e0_q) && (k_w >= e1_q))));

  // R5: at the top entry, the neighbour snapshot equals the entry itself.
  a_r5_top_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_INTERP) && (idx_q == LAST)) |-> (e1_q == e0_q));

  // R6: a unity factor returns the drive period unchanged.
  a_r6_unity_passes: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SCALE) && (k_q == K_ONE)) |=> (out_period == per_q));

  // R7: a factor of at least 1.0 never wraps the result below the input.
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SCALE) && (k_q >= K_ONE)) |=> (out_period >= per_q));
endmodule

// File: tb/tb_phase_corr_table.sv
`timescale 1ns/1ps
module tb_phase_corr_table;
  localparam int PER_MAX = 30'h3FFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_addr = '0;
  logic [17:0] tbl_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [24:0] in_phase = '0;
  logic [29:0] in_period = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [29:0] out_period;

  phase_corr_table dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .in_period(in_period), .out_valid(out_valid),
    .out_ready(out_ready), .out_period(out_period)
  );

  always #2 clk = ~clk;

  int     errors = 0;
  int     checks = 0;
  int     tbl_m [32];
  bit     busy = 0;
  int     lat = 0;
  bit     acc = 0;
  longint exp_q = 0;
  string  cur_req = "R1";

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Reference model, written from the requirement text.
  function automatic longint model(input logic [24:0] ph, input logic [29:0] per);
    int idx;
    longint fr, e0, e1, k, p;
    idx = ((int'(ph) >> 20) & 31) ^ 16;              // R3
    fr  = longint'(ph) & 64'hFFFFF;
    e0  = tbl_m[idx];
    e1  = (idx == 31) ? e0 : longint'(tbl_m[idx + 1]); // R5
    k   = e0 + (((e1 - e0) * fr) >>> 20);            // R4
    p   = (longint'(per) * k) >>> 16;                // R6
    if (p > PER_MAX) p = PER_MAX;                     // R7
    return p;
  endfunction

  // Runs once per cycle, before the edge that consumes the current inputs.
  task automatic monitor();
    if (busy) lat++;
    check(in_ready === !busy, "R2 in_ready", longint'(in_ready), longint'(!busy));
    check(out_valid === (busy && lat >= 3), "R2 out_valid", longint'(out_valid),
          longint'(busy && lat >= 3));
    if (out_valid && out_ready) begin
      check(longint'(out_period) == exp_q, cur_req, longint'(out_period), exp_q);
      busy = 0;
    end
    if (in_valid && in_ready) begin
      exp_q = model(in_phase, in_period);
      busy  = 1;
      lat   = 0;
      acc   = 1;
    end
    if (tbl_we) tbl_m[tbl_addr] = int'(tbl_data); // R8: lands after this sample
  endtask

  task automatic tick();
    monitor();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    tbl_we = 1'b1; tbl_addr = 5'(a); tbl_data = 18'(d);
    tick();
    tbl_we = 1'b0;
  endtask

  task automatic start(input logic [24:0] ph, input logic [29:0] per);
    in_phase = ph; in_period = per; in_valid = 1'b1; acc = 0;
    while (!acc) tick();
    in_valid = 1'b0;
  endtask

  task automatic finish_word();
    while (busy) tick();
  endtask

  task automatic send(input logic [24:0] ph, input logic [29:0] per);
    start(ph, per);
    finish_word();
  endtask

  function automatic logic [29:0] rnd_per();
    return 30'h08000000 + 30'($urandom() & 32'h0FFFFFFF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) tbl_m[i] = 65536;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R1 in_ready", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1 after reset", longint'(in_ready), 1);

    cur_req = "R9";
    for (int n = 0; n < 6; n++) send(25'($urandom()), rnd_per());
    cur_req = "R6";
    send(25'h0000000, 30'h3FFFFFFF);
    send(25'h1555555, 30'h00100000);

    cur_req = "R8";
    for (int i = 0; i < 32; i++) wr(i, 40000 + i * 3000);
    cur_req = "R3";
    send(25'h1000000, 30'h00100000);   // -1.0 -> entry 0
    send(25'h0000000, 30'h00100000);   // 0.0 -> entry 16
    send(25'h0080000, 30'h00100000);   // half way between 16 and 17
    send(25'h1F80000, 30'h00100000);   // half way between 15 and 16
    cur_req = "R4";
    for (int n = 0; n < 10; n++) send(25'($urandom()), rnd_per());
    cur_req = "R5";
    send(25'h0FFFFFF, 30'h00100000);
    send(25'h0F80000, 30'h01234567);

    cur_req = "R8";
    for (int i = 0; i < 32; i++) wr(i, 120000 - i * 2500);
    cur_req = "R4";
    for (int n = 0; n < 8; n++) send(25'($urandom()), rnd_per());
    cur_req = "R5";
    send(25'h0FFFFFF, 30'h02000000);

    cur_req = "R2";
    out_ready = 1'b0;
    start(25'h0123456, 30'h01000000);
    in_phase = 25'h1ABCDEF; in_period = 30'h00ABCDEF; in_valid = 1'b1; acc = 0;
    repeat (8) tick();
    out_ready = 1'b1;
    while (!acc) tick();
    in_valid = 1'b0;
    finish_word();

    cur_req = "R8";
    in_phase = 25'h0000000; in_period = 30'h00400000; in_valid = 1'b1; acc = 0;
    tbl_we = 1'b1; tbl_addr = 5'd16; tbl_data = 18'd200000;
    tick();
    tbl_we = 1'b0; in_valid = 1'b0;
    finish_word();
    start(25'h0000000, 30'h00400000);
    tbl_we = 1'b1; tbl_addr = 5'd16; tbl_data = 18'd30000;
    tick();
    tbl_we = 1'b0;
    finish_word();
    send(25'h0000000, 30'h00400000);

    cur_req = "R7";
    for (int i = 0; i < 32; i++) wr(i, 131072);
    send(25'h0000000, 30'h3FFFF000);
    send(25'h1234567, 30'h20000000);
    send(25'h0765432, 30'h1FFFFFFF);

    repeat (2) tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule